// File: doc/BRIEF.md
# Single-Source Fast Interrupt Selector

This block picks exactly one interrupt source out of three raw source banks and drives it onto a dedicated fast-interrupt line. A single control register, reachable through a plain register bus, holds a 7-bit source index and an enable bit. Any source can be chosen: the 32 lines of the first peripheral bank, the 32 lines of the second peripheral bank, or the 8 lines of the basic bank.

The fast-interrupt output is the raw level of the chosen source gated by the enable bit, and it is registered once. It ignores the normal interrupt enable masks completely. Choosing a source here does not take it off the normal interrupt path. Software that wants only the fast line must disable the source on the normal path itself. If it does not, both lines assert together.

Top module: `fiq_route_top`

## Requirements
- R1: A synchronous active-low reset clears the control register, so it reads back 0, and drives `fiq_out` low.
- R2: A write to offset 0x0C stores `bus_wdata[6:0]` as the source index and `bus_wdata[7]` as the enable. Reading offset 0x0C returns `{24'b0, enable, index}`, and bits 31:8 always read as zero.
- R3: A write to any other offset leaves the control register unchanged. A read of any other offset returns zero.
- R4: Index values 0 to 31 select bank-1 source bits 0 to 31.
- R5: Index values 32 to 63 select bank-2 source bits 0 to 31, so that index 32+k selects bit k.
- R6: Index values 64 to 71 select bank-0 source bits 0 to 7, so that index 64+k selects bit k.
- R7: An index from 72 to 127 selects no source, and `fiq_out` stays low whatever the source levels are.
- R8: While the enable bit is 0, `fiq_out` stays low whatever the source levels are.
- R9: `fiq_out` follows the selected source level one clock edge after that level is present. The same one-edge delay applies after a control-register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_bank0 | input | 8 | Raw basic-bank source levels |
| src_bank1 | input | 32 | Raw bank-1 source levels |
| src_bank2 | input | 32 | Raw bank-2 source levels |
| fiq_out | output | 1 | Registered fast-interrupt request |

## Verification
The bench puts a single active source at each bank edge: indices 0, 31, 32, 63, 64 and 71. It also places the same bit number in a different bank, where it must not fire. A design with a bank order swapped, or an offset off by one, would either miss the lone active bit or fire on the decoy.

Out-of-range indices 72, 100 and 127 are tried with every source high. A decoder that wraps or truncates the index would raise the line for these.

A write whose upper data bits are all ones checks that the register stores only its byte and that the upper bits read back as zero. Writes to neighbouring offsets must leave the register alone.

Sampling just before and just after the edge that follows a source change would catch an output that is combinational or delayed by two registers.

// File: rtl/fiq_route_pkg.sv
// Package: shared defaults and the bank-select encoding for the fast
// interrupt selector. Assumes the bank order bank1, bank2, bank0 in index space.
package fiq_route_pkg;

    parameter int DEF_ADDR_W   = 8;
    parameter int DEF_DATA_W   = 32;
    parameter int DEF_B0_W     = 8;
    parameter int DEF_B1_W     = 32;
    parameter int DEF_B2_W     = 32;
    parameter int DEF_CTRL_OFS = 'h0C;

    // Which bank a decoded index falls into.
    typedef enum logic [1:0] {
        BSEL_BANK1 = 2'd0,
        BSEL_BANK2 = 2'd1,
        BSEL_BANK0 = 2'd2,
        BSEL_NONE  = 2'd3
    } bank_sel_e;

endpackage

// File: rtl/fiq_route_ctrl_reg.sv
// Control register: holds the source index and the enable bit. It decodes
// one offset on a simple write-strobe bus and gives a combinational read-back
// with unused bits at zero. Assumes bus_wr is a single-cycle strobe.
module fiq_route_ctrl_reg #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 7,
    parameter int CTRL_OFS = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ctrl_en,
    output logic [IDX_W-1:0]  ctrl_idx
);

    localparam int PAD_W = DATA_W - IDX_W - 1;

    logic addr_hit;
    logic unused_wdata_hi;

    // Decode the register offset.
    assign addr_hit        = (bus_addr == ADDR_W'(CTRL_OFS));
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:IDX_W+1];

    // Hold index and enable; clear on reset, load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_idx <= '0;
        end else if (bus_wr && addr_hit) begin
            ctrl_en  <= bus_wdata[IDX_W];
            ctrl_idx <= bus_wdata[IDX_W-1:0];
        end
    end

    // Read-back: the register at its offset, zero elsewhere.
    always_comb begin
        if (addr_hit) begin
            bus_rdata = {{PAD_W{1'b0}}, ctrl_en, ctrl_idx};
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/fiq_route_src_mux.sv
// Source multiplexer: splits the index into a bank and an offset in the
// order bank1, bank2, bank0, then picks that bank's bit. Indices past the
// last source select nothing. Purely combinational.
module fiq_route_src_mux
    import fiq_route_pkg::*;
#(
    parameter int B0_W  = 8,
    parameter int B1_W  = 32,
    parameter int B2_W  = 32,
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [B0_W-1:0]  src_bank0,
    input  logic [B1_W-1:0]  src_bank1,
    input  logic [B2_W-1:0]  src_bank2,
    output logic             hit
);

    localparam int NUM_SRC = B1_W + B2_W + B0_W;
    localparam int MAX_W   = (B1_W > B2_W) ? ((B1_W > B0_W) ? B1_W : B0_W)
                                           : ((B2_W > B0_W) ? B2_W : B0_W);
    localparam int OFS_W   = (MAX_W > 1) ? $clog2(MAX_W) : 1;

    bank_sel_e        bank;
    logic [IDX_W-1:0] ofs_full;
    logic [OFS_W-1:0] ofs;
    logic [B0_W-1:0]  hot0;
    logic [B1_W-1:0]  hot1;
    logic [B2_W-1:0]  hot2;
    logic             hit0;
    logic             hit1;
    logic             hit2;
    logic             unused_ofs_hi;

    // Split the index into a bank and an offset inside that bank.
    always_comb begin
        if (idx < IDX_W'(B1_W)) begin
            bank     = BSEL_BANK1;
            ofs_full = idx;
        end else if (idx < IDX_W'(B1_W + B2_W)) begin
            bank     = BSEL_BANK2;
            ofs_full = idx - IDX_W'(B1_W);
        end else if (idx < IDX_W'(NUM_SRC)) begin
            bank     = BSEL_BANK0;
            ofs_full = idx - IDX_W'(B1_W + B2_W);
        end else begin
            bank     = BSEL_NONE;
            ofs_full = '0;
        end
    end

    assign ofs           = ofs_full[OFS_W-1:0];
    assign unused_ofs_hi = ^ofs_full;

    // One-hot offset decode for each bank.
    for (genvar j = 0; j < B0_W; j++) begin : g_hot0
        assign hot0[j] = (ofs == OFS_W'(j));
    end
    for (genvar j = 0; j < B1_W; j++) begin : g_hot1
        assign hot1[j] = (ofs == OFS_W'(j));
    end
    for (genvar j = 0; j < B2_W; j++) begin : g_hot2
        assign hot2[j] = (ofs == OFS_W'(j));
    end

    assign hit0 = |(hot0 & src_bank0);
    assign hit1 = |(hot1 & src_bank1);
    assign hit2 = |(hot2 & src_bank2);

    // Pick the decoded bank's bit; an out-of-range index gives 0.
    always_comb begin
        unique case (bank)
            BSEL_BANK1: hit = hit1;
            BSEL_BANK2: hit = hit2;
            BSEL_BANK0: hit = hit0;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fiq_route_out_reg.sv
// Output stage: gates the selected level with the enable bit and registers
// it once. Assumes the source levels are already synchronous to clk.
module fiq_route_out_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic en,
    output logic fiq_q
);

    // Register the gated request; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_q <= 1'b0;
        end else begin
            fiq_q <= hit & en;
        end
    end

endmodule

// File: rtl/fiq_route_top.sv
// Top: fast-interrupt selector. It joins the control register, the source
// multiplexer and the output stage. The normal interrupt path is outside this
// block and is not affected by the selection.
module fiq_route_top
    import fiq_route_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int DATA_W   = DEF_DATA_W,
    parameter int B0_W     = DEF_B0_W,
    parameter int B1_W     = DEF_B1_W,
    parameter int B2_W     = DEF_B2_W,
    parameter int CTRL_OFS = DEF_CTRL_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [B0_W-1:0]   src_bank0,
    input  logic [B1_W-1:0]   src_bank1,
    input  logic [B2_W-1:0]   src_bank2,
    output logic              fiq_out
);

    localparam int NUM_SRC = B1_W + B2_W + B0_W;
    localparam int IDX_W   = $clog2(NUM_SRC);

    logic             ctrl_en;
    logic [IDX_W-1:0] ctrl_idx;
    logic             sel_hit;

    fiq_route_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .CTRL_OFS (CTRL_OFS)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_en   (ctrl_en),
        .ctrl_idx  (ctrl_idx)
    );

    fiq_route_src_mux #(
        .B0_W  (B0_W),
        .B1_W  (B1_W),
        .B2_W  (B2_W),
        .IDX_W (IDX_W)
    ) i_mux (
        .idx       (ctrl_idx),
        .src_bank0 (src_bank0),
        .src_bank1 (src_bank1),
        .src_bank2 (src_bank2),
        .hit       (sel_hit)
    );

    fiq_route_out_reg i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (sel_hit),
        .en    (ctrl_en),
        .fiq_q (fiq_out)
    );

endmodule

// File: rtl/fiq_route_checker.sv
// Checker: temporal properties of the fast interrupt selector, bound to the
// top module. It works out the expected source level on its own from the
// flattened index space.
module fiq_route_checker #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int B0_W     = 8,
    parameter int B1_W     = 32,
    parameter int B2_W     = 32,
    parameter int CTRL_OFS = 'h0C,
    parameter int IDX_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [B0_W-1:0]   src_bank0,
    input logic [B1_W-1:0]   src_bank1,
    input logic [B2_W-1:0]   src_bank2,
    input logic              ctrl_en,
    input logic [IDX_W-1:0]  ctrl_idx,
    input logic              fiq_out
);

    localparam int NUM_SRC = B1_W + B2_W + B0_W;

    logic [NUM_SRC-1:0] flat_src;
    logic               exp_lvl;
    logic               rst_seen;
    logic               unused_wdata;

    assign flat_src     = {src_bank0, src_bank2, src_bank1};
    assign unused_wdata = ^bus_wdata;

    // Expected level of the indexed source, from the flattened order.
    always_comb begin
        exp_lvl = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ctrl_idx == IDX_W'(i)) exp_lvl = flat_src[i];
        end
    end

    // Remember that reset was low on the previous edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (!fiq_out && !ctrl_en && ctrl_idx == '0));

    assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CTRL_OFS))
        |=> ({ctrl_en, ctrl_idx} == $past(bus_wdata[IDX_W:0])));

    assert_other_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(CTRL_OFS))
        |=> ($stable(ctrl_en) && $stable(ctrl_idx)));

    assert_bank1_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_idx < IDX_W'(B1_W)) |=> (fiq_out == $past(exp_lvl)));

    assert_bank2_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_idx >= IDX_W'(B1_W) && ctrl_idx < IDX_W'(B1_W + B2_W))
        |=> (fiq_out == $past(exp_lvl)));

    assert_bank0_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_idx >= IDX_W'(B1_W + B2_W) && ctrl_idx < IDX_W'(NUM_SRC))
        |=> (fiq_out == $past(exp_lvl)));

    assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idx >= IDX_W'(NUM_SRC)) |=> !fiq_out);

    assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !fiq_out);

    assert_one_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_out) |-> $past(ctrl_en && exp_lvl));

endmodule

bind fiq_route_top fiq_route_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .B0_W     (B0_W),
    .B1_W     (B1_W),
    .B2_W     (B2_W),
    .CTRL_OFS (CTRL_OFS),
    .IDX_W    (IDX_W)
) i_fiq_route_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .src_bank0 (src_bank0),
    .src_bank1 (src_bank1),
    .src_bank2 (src_bank2),
    .ctrl_en   (ctrl_en),
    .ctrl_idx  (ctrl_idx),
    .fiq_out   (fiq_out)
);

// File: tb/test_fiq_route_top.sv
// Directed bench for the fast interrupt selector. Inputs change on the
// falling edge and outputs are sampled there too.
module test_fiq_route_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  src_bank0;
    logic [31:0] src_bank1;
    logic [31:0] src_bank2;
    logic        fiq_out;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] CTRL = 8'h0C;

    always #10 clk = ~clk;

    fiq_route_top i_fiq_route_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_bank0 (src_bank0),
        .src_bank1 (src_bank1),
        .src_bank2 (src_bank2),
        .fiq_out   (fiq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
        bus_addr  = CTRL;
    endtask

    task automatic set_src(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
        src_bank0 = b0;
        src_bank1 = b1;
        src_bank2 = b2;
    endtask

    // Reset clears the register and holds the output low.
    task automatic t_reset();
        set_src('1, '1, '1);
        rst_n = 1'b0;
        repeat (3) step();
        check(32'(fiq_out), 0, "R1 fiq during reset");
        rst_n = 1'b1;
        step();
        bus_addr = CTRL;
        #1;
        check(bus_rdata, 0, "R1 ctrl after reset");
        check(32'(fiq_out), 0, "R1 fiq after reset");
    endtask

    // Store and read back, upper bits ignored.
    task automatic t_readback();
        set_src('0, '0, '0);
        bus_write(CTRL, 32'hFFFF_FF85);
        #1;
        check(bus_rdata, 32'h0000_0085, "R2 readback");
        bus_write(CTRL, 32'h0000_0047);
        #1;
        check(bus_rdata, 32'h0000_0047, "R2 readback disabled");
    endtask

    // Other offsets neither store nor read.
    task automatic t_other_offsets();
        bus_write(CTRL, 32'h0000_0085);
        bus_write(8'h08, 32'h0000_0000);
        bus_write(8'h10, 32'h0000_00FF);
        #1;
        check(bus_rdata, 32'h0000_0085, "R3 ctrl unchanged");
        bus_addr = 8'h08;
        #1;
        check(bus_rdata, 0, "R3 other offset reads zero");
        bus_addr = CTRL;
        set_src('0, 32'h0000_0020, '0);
        step();
        check(32'(fiq_out), 1, "R3 selection kept index 5");
    endtask

    // Select a source and check the fire and no-fire cases.
    task automatic probe(input int idx, input logic [7:0] b0, input logic [31:0] b1,
                         input logic [31:0] b2, input logic exp, input string req);
        set_src(b0, b1, b2);
        bus_write(CTRL, 32'h80 | 32'(idx));
        step();
        check(32'(fiq_out), 32'(exp), req);
    endtask

    task automatic t_bank1();
        probe(0,  '0, 32'h0000_0001, '0, 1'b1, "R4 idx0");
        probe(31, '0, 32'h8000_0000, '0, 1'b1, "R4 idx31");
        probe(5,  '1, ~32'h20, '1, 1'b0, "R4 idx5 only others high");
        probe(7,  8'h80, '0, 32'h80, 1'b0, "R4 idx7 decoy in other banks");
    endtask

    task automatic t_bank2();
        probe(32, '0, '0, 32'h0000_0001, 1'b1, "R5 idx32");
        probe(63, '0, '0, 32'h8000_0000, 1'b1, "R5 idx63");
        probe(47, '0, 32'h0000_8000, '0, 1'b0, "R5 idx47 decoy bank1");
        probe(47, '0, '0, 32'h0000_8000, 1'b1, "R5 idx47");
    endtask

    task automatic t_bank0();
        probe(64, 8'h01, '0, '0, 1'b1, "R6 idx64");
        probe(71, 8'h80, '0, '0, 1'b1, "R6 idx71");
        probe(71, 8'h7F, 32'h80, 32'h80, 1'b0, "R6 idx71 decoys");
    endtask

    task automatic t_out_of_range();
        probe(72,  '1, '1, '1, 1'b0, "R7 idx72");
        probe(100, '1, '1, '1, 1'b0, "R7 idx100");
        probe(127, '1, '1, '1, 1'b0, "R7 idx127");
    endtask

    task automatic t_disable();
        set_src('1, '1, '1);
        bus_write(CTRL, 32'h0000_0003);
        step();
        check(32'(fiq_out), 0, "R8 enable clear idx3");
        bus_write(CTRL, 32'h0000_0040);
        step();
        check(32'(fiq_out), 0, "R8 enable clear idx64");
    endtask

    // One-edge latency from source change to output.
    task automatic t_latency();
        set_src('0, '0, '0);
        bus_write(CTRL, 32'h0000_008A);
        step();
        check(32'(fiq_out), 0, "R9 idle before");
        src_bank1 = 32'h0000_0400;
        #1;
        check(32'(fiq_out), 0, "R9 not combinational");
        step();
        check(32'(fiq_out), 1, "R9 rises after one edge");
        src_bank1 = '0;
        #1;
        check(32'(fiq_out), 1, "R9 holds until edge");
        step();
        check(32'(fiq_out), 0, "R9 falls after one edge");
        src_bank1 = 32'h0000_0400;
        bus_write(CTRL, 32'h0000_000A);
        check(32'(fiq_out), 1, "R9 old enable at write edge");
        step();
        check(32'(fiq_out), 0, "R9 write takes one more edge");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_addr  = CTRL;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        set_src('0, '0, '0);
        @(negedge clk);
        t_reset();
        t_readback();
        t_other_offsets();
        t_bank1();
        t_bank2();
        t_bank0();
        t_out_of_range();
        t_disable();
        t_latency();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule